// File: doc/BRIEF.md
# Iterative Signed Divider with Zero-Skip

The block divides two 64-bit operands over many clock cycles, one quotient bit per cycle with a plain shift-and-subtract loop. It can return the quotient or the remainder, and it can treat the operands as unsigned or as two's-complement signed values. A one-cycle `go` pulse starts an operation and captures the operands together with three control flags: signed, remainder-select and half-width. The answer appears on `result` while `done` is high for one cycle. The answer stays on `result` until the next accepted `go`.

Signed operands may arrive negative. In that case the unit spends one extra cycle turning them into magnitudes before it starts iterating. The sign is corrected combinationally when the result is formed. When the remaining partial remainder is zero and the next eight dividend bits are also zero, one cycle retires eight zero quotient bits at once. Small dividends, including every half-width operation, therefore finish well before the 64-step worst case.

In half-width mode only the low 32 bits of each operand are used. They are extended to 64 bits according to the signed flag, and the 32-bit answer is returned sign-extended to 64 bits.

Top module: `sdiv_iter`

## Requirements
- R1: With `op_signed`=0, `result` equals floor(op_a/op_b) when `op_rem`=0 and op_a mod op_b when `op_rem`=1, with both operands unsigned.
- R2: With `op_signed`=1, both operands are two's-complement values. The quotient is negative exactly when one operand is negative. The remainder carries the sign of the dividend. With `op_signed`=0, no sign correction is applied, even when bit 63 of an operand is set.
- R3: An operation takes N iteration cycles. N is counted as follows. Let M be the dividend magnitude and c the number of quotient bits retired so far. A cycle retires 8 bits when all three of these hold: c<56, the partial remainder of the top c bits of M is zero, and bits 63:56 of (M shifted left by c) are zero. Otherwise the cycle retires 1 bit. Iteration ends when c reaches 64.
- R4: When `op_signed`=1 and either extended operand is negative, exactly one extra cycle is added before iteration. Otherwise no cycle is added. `done` rises on the clock edge that comes (extra + N) edges after the edge that accepts `go`.
- R5: A divisor of zero gives `result`=0 for both quotient and remainder. `done` still arrives after the R4 latency.
- R6: With `op_half`=1, each operand is bits 31:0, sign-extended when signed and zero-extended otherwise. `result` is bits 31:0 of the answer, sign-extended to 64 bits.
- R7: `done` is high for exactly one cycle. `result` keeps its value after `done` until the next `go` is accepted.
- R8: A `go` that arrives while an operation is in progress is ignored and does not change the result of the operation in flight.
- R9: A synchronous `rst` returns the unit to idle. `done` stays low until a new operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only when idle |
| op_a | input | 64 | Dividend |
| op_b | input | 64 | Divisor |
| op_signed | input | 1 | 1: operands are two's-complement |
| op_rem | input | 1 | 1: return remainder, 0: return quotient |
| op_half | input | 1 | 1: 32-bit operation on the low halves |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Quotient or remainder |

## Verification
The hardest situation to reach is an exact latency, because it depends on where the zero-skip fires part way through an operation. Reaching it needs dividends whose partial remainder returns to zero with a zero byte following. The stimulus therefore mixes tiny dividends, dividends with leading zero bytes, all-ones dividends that never skip, half-width operands, and signed cases that add the negation cycle. For every operation, the bench derives the expected latency from the arithmetic partial-remainder rule and compares `done` against it on every cycle. A `go` issued mid-operation and a reset issued mid-operation cover the ignore and abort paths.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NEG  = 2'd1,
      ST_RUN  = 2'd2
   } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
// Operand extension for full and half width, plus operand sign detection.
module sdiv_prep #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sgn,
   input  logic         half,
   output logic [W-1:0] ea,
   output logic [W-1:0] eb,
   output logic         a_neg,
   output logic         b_neg
);
   localparam int H = W / 2;

   logic [W-1:0] a_half, b_half;

   always_comb begin
      a_half = sgn ? {{H{a[H-1]}}, a[H-1:0]} : {{H{1'b0}}, a[H-1:0]};
      b_half = sgn ? {{H{b[H-1]}}, b[H-1:0]} : {{H{1'b0}}, b[H-1:0]};
      ea     = half ? a_half : a;
      eb     = half ? b_half : b;
      a_neg  = sgn & ea[W-1];
      b_neg  = sgn & eb[W-1];
   end
endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
// One iteration: either a single restoring step or a SKIP-bit zero retire.
module sdiv_step #(
   parameter int W    = 64,
   parameter int SKIP = 8,
   parameter int CW   = 7
) (
   input  logic [2*W-1:0] acc,
   input  logic [W-1:0]   quot,
   input  logic [W-1:0]   dvs,
   input  logic [CW-1:0]  cnt,
   output logic [2*W-1:0] acc_nx,
   output logic [W-1:0]   quot_nx,
   output logic [CW-1:0]  cnt_nx
);
   logic [W:0]   top;
   logic [W:0]   diff;
   logic         ge;
   logic         take;

   generate
      if (SKIP > 0) begin : g_skip
         localparam logic [CW-1:0] LIM = CW'(W - SKIP);
         assign take = (acc[2*W-1:W-SKIP] == '0) && (cnt < LIM);
      end else begin : g_noskip
         assign take = 1'b0;
      end
   endgenerate

   always_comb begin
      top  = acc[2*W-1:W-1];
      ge   = top >= {1'b0, dvs};
      diff = top - {1'b0, dvs};
      if (take) begin
         acc_nx  = acc << SKIP;
         quot_nx = quot << SKIP;
         cnt_nx  = cnt + CW'(SKIP);
      end else begin
         acc_nx  = {(ge ? diff[W-1:0] : top[W-1:0]), acc[W-2:0], 1'b0};
         quot_nx = {quot[W-2:0], ge};
         cnt_nx  = cnt + CW'(1);
      end
   end
endmodule

// File: rtl/sdiv_fmt.sv
`timescale 1ns/1ps
// Result selection, sign correction, half-width extension, zero divisor.
module sdiv_fmt #(
   parameter int W = 64
) (
   input  logic [W-1:0] quot,
   input  logic [W-1:0] rem,
   input  logic         sel_rem,
   input  logic         neg_q,
   input  logic         neg_r,
   input  logic         half,
   input  logic         dz,
   output logic [W-1:0] res
);
   localparam int H = W / 2;

   logic [W-1:0] mag, val;
   logic         neg;

   always_comb begin
      mag = sel_rem ? rem : quot;
      neg = sel_rem ? neg_r : neg_q;
      val = neg ? (~mag + W'(1)) : mag;
      if (dz)
         res = '0;
      else if (half)
         res = {{H{val[H-1]}}, val[H-1:0]};
      else
         res = val;
   end
endmodule

// File: rtl/sdiv_iter.sv
`timescale 1ns/1ps
module sdiv_iter #(
   parameter int W    = 64,
   parameter int SKIP = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         go,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         op_signed,
   input  logic         op_rem,
   input  logic         op_half,
   output logic         done,
   output logic [W-1:0] result
);
   import sdiv_pkg::*;

   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST = CW'(W);

   generate
      if ((W % 2) != 0 || W < 8) begin : g_bad_w
         $error("sdiv_iter: W must be even and at least 8");
      end
      if (SKIP < 0 || SKIP >= W) begin : g_bad_skip
         $error("sdiv_iter: SKIP must be in 0..W-1");
      end
   endgenerate

   sdiv_state_e       state;
   logic [2*W-1:0]    acc_q;
   logic [W-1:0]      quot_q, dvs_q;
   logic [CW-1:0]     cnt_q;
   logic              an_q, bn_q, negq_q, negr_q, rem_q, half_q, dz_q, done_q;
   logic              busy;

   logic [W-1:0]      ea, eb;
   logic              a_neg, b_neg;
   logic [2*W-1:0]    acc_nx;
   logic [W-1:0]      quot_nx;
   logic [CW-1:0]     cnt_nx;

   assign busy = (state != ST_IDLE);

   sdiv_prep #(.W(W)) u_prep (
      .a(op_a), .b(op_b), .sgn(op_signed), .half(op_half),
      .ea(ea), .eb(eb), .a_neg(a_neg), .b_neg(b_neg)
   );

   sdiv_step #(.W(W), .SKIP(SKIP), .CW(CW)) u_step (
      .acc(acc_q), .quot(quot_q), .dvs(dvs_q), .cnt(cnt_q),
      .acc_nx(acc_nx), .quot_nx(quot_nx), .cnt_nx(cnt_nx)
   );

   sdiv_fmt #(.W(W)) u_fmt (
      .quot(quot_q), .rem(acc_q[2*W-1:W]), .sel_rem(rem_q),
      .neg_q(negq_q), .neg_r(negr_q), .half(half_q), .dz(dz_q),
      .res(result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         acc_q  <= '0;
         quot_q <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         an_q   <= 1'b0;
         bn_q   <= 1'b0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         rem_q  <= 1'b0;
         half_q <= 1'b0;
         dz_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  acc_q  <= {{W{1'b0}}, ea};
                  dvs_q  <= eb;
                  quot_q <= '0;
                  cnt_q  <= '0;
                  an_q   <= a_neg;
                  bn_q   <= b_neg;
                  negq_q <= a_neg ^ b_neg;
                  negr_q <= a_neg;
                  rem_q  <= op_rem;
                  half_q <= op_half;
                  dz_q   <= (eb == '0);
                  state  <= (a_neg || b_neg) ? ST_NEG : ST_RUN;
               end
            end
            ST_NEG: begin
               if (an_q) acc_q[W-1:0] <= ~acc_q[W-1:0] + W'(1);
               if (bn_q) dvs_q        <= ~dvs_q + W'(1);
               state <= ST_RUN;
            end
            ST_RUN: begin
               acc_q  <= acc_nx;
               quot_q <= quot_nx;
               cnt_q  <= cnt_nx;
               if (cnt_nx == LAST) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done = done_q;
endmodule

// File: rtl/sdiv_iter_chk.sv
`timescale 1ns/1ps
module sdiv_iter_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst,
   input logic         go,
   input logic         done,
   input logic [W-1:0] result,
   input logic         busy,
   input logic         dz,
   input logic         half
);
   localparam int H = W / 2;

   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R7

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
      (done && !go) |=> $stable(result)); // R7

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (rst)
      (go && !busy) |=> busy); // R4

   AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst || rst_d)
      $fell(busy) |-> done); // R8

   AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
      (done && dz) |-> (result == '0)); // R5

   AST_HALF_SEXT: assert property (@(posedge clk) disable iff (rst)
      (done && half) |-> (result[W-1:H] == {H{result[H-1]}})); // R6

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
      rst |=> (!busy && !done)); // R9
endmodule

bind sdiv_iter sdiv_iter_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .go(go), .done(done), .result(result),
   .busy(busy), .dz(dz_q), .half(half_q)
);

// File: tb/tb_sdiv_iter.sv
`timescale 1ns/1ps
module tb_sdiv_iter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        go = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic        op_signed = 1'b0, op_rem = 1'b0, op_half = 1'b0;
   logic        done;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #2.5 clk = ~clk;

   sdiv_iter dut (
      .clk(clk), .rst(rst), .go(go), .op_a(op_a), .op_b(op_b),
      .op_signed(op_signed), .op_rem(op_rem), .op_half(op_half),
      .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic logic [63:0] ext(input logic [63:0] v, input bit sgn, input bit half);
      if (!half) return v;
      return sgn ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
   endfunction

   function automatic logic [63:0] neg64(input logic [63:0] v);
      return 64'd0 - v;
   endfunction

   function automatic logic [63:0] ref_res(input logic [63:0] a, input logic [63:0] b,
                                           input bit sgn, input bit rem, input bit half);
      logic [63:0] ea, eb, ma, mb, q, r, v;
      bit an, bn;
      ea = ext(a, sgn, half);
      eb = ext(b, sgn, half);
      an = sgn && ea[63];
      bn = sgn && eb[63];
      ma = an ? neg64(ea) : ea;
      mb = bn ? neg64(eb) : eb;
      if (mb == 0) return 64'd0;
      q = ma / mb;
      r = ma % mb;
      if (rem) v = an ? neg64(r) : r;
      else     v = (an != bn) ? neg64(q) : q;
      if (half) v = {{32{v[31]}}, v[31:0]};
      return v;
   endfunction

   function automatic int ref_lat(input logic [63:0] a, input logic [63:0] b,
                                  input bit sgn, input bit half);
      logic [63:0] ea, eb, ma, mb, pre, rr, sh;
      bit an, bn;
      int c, n;
      ea = ext(a, sgn, half);
      eb = ext(b, sgn, half);
      an = sgn && ea[63];
      bn = sgn && eb[63];
      ma = an ? neg64(ea) : ea;
      mb = bn ? neg64(eb) : eb;
      c = 0;
      n = 0;
      while (c < 64) begin
         pre = (c == 0) ? 64'd0 : (ma >> (64 - c));
         rr  = (mb == 0) ? pre : (pre % mb);
         sh  = ma << c;
         if (c < 56 && rr == 0 && sh[63:56] == 8'd0) c += 8;
         else c += 1;
         n++;
      end
      return n + ((an || bn) ? 1 : 0);
   endfunction

   bit          m_busy = 0;
   bit          m_exp_done = 0;
   int          m_left = 0;
   logic [63:0] m_res = '0;
   string       m_tag = "R1";
   string       cur_tag = "R1";

   always @(posedge clk) begin
      if (rst) begin
         m_busy     = 0;
         m_exp_done = 0;
      end else begin
         m_exp_done = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy     = 0;
               m_exp_done = 1;
            end
         end else if (go) begin
            m_busy = 1;
            m_left = ref_lat(op_a, op_b, op_signed, op_half);
            m_res  = ref_res(op_a, op_b, op_signed, op_rem, op_half);
            m_tag  = cur_tag;
         end
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!rst && !ended) begin
         chk(done == m_exp_done, "R7 done strobe vs model", 64'(done), 64'(m_exp_done));
         if (m_exp_done)
            chk(result == m_res, m_tag, result, m_res);
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit sgn,
                         input bit rem, input bit half, input string tag);
      int cyc, lat;
      logic [63:0] held;
      lat = ref_lat(a, b, sgn, half);
      cur_tag = tag;
      @(negedge clk);
      op_a = a; op_b = b; op_signed = sgn; op_rem = rem; op_half = half; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == lat, {tag, " latency R3 R4"}, 64'(cyc), 64'(lat));
      held = result;
      @(negedge clk);
      chk(result == held && !done, "R7 result held, done low", result, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R9 done low in reset", 64'(done), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R9 done low after reset", 64'(done), 64'd0);

      run_op(64'd100, 64'd7, 0, 0, 0, "R1 unsigned quotient");
      run_op(64'd100, 64'd7, 0, 1, 0, "R1 unsigned remainder");
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, "R3 no skip quotient");
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 0, 1, 0, "R3 no skip remainder");
      run_op(64'd5, 64'd3, 0, 0, 0, "R3 small dividend skip");
      run_op(64'h0000_0100_0000_0000, 64'd1, 0, 0, 0, "R3 skip stops at one bit");
      run_op(64'h00F0_0000_0000_0000, 64'h10, 0, 1, 0, "R3 mid skip");
      run_op(neg64(64'd100), 64'd7, 1, 0, 0, "R2 neg dividend quotient");
      run_op(neg64(64'd100), 64'd7, 1, 1, 0, "R2 neg dividend remainder");
      run_op(64'd100, neg64(64'd7), 1, 0, 0, "R2 neg divisor quotient");
      run_op(64'd100, neg64(64'd7), 1, 1, 0, "R2 neg divisor remainder");
      run_op(neg64(64'd100), neg64(64'd7), 1, 0, 0, "R2 both neg quotient");
      run_op(neg64(64'd100), neg64(64'd7), 1, 1, 0, "R2 both neg remainder");
      run_op(64'd100, 64'd7, 1, 0, 0, "R4 signed positive no extra cycle");
      run_op(neg64(64'd100), 64'd7, 0, 0, 0, "R2 unsigned no correction");
      run_op(64'h8000_0000_0000_0000, neg64(64'd1), 1, 0, 0, "R2 most negative by -1");
      run_op(64'd12345, 64'd0, 0, 0, 0, "R5 zero divisor quotient");
      run_op(neg64(64'd9), 64'd0, 1, 1, 0, "R5 zero divisor remainder");
      run_op(64'hDEAD_BEEF_FFFF_FF9C, 64'hAAAA_AAAA_0000_0007, 1, 0, 1, "R6 half signed quotient");
      run_op(64'hDEAD_BEEF_FFFF_FF9C, 64'h0000_0000_0000_0007, 1, 1, 1, "R6 half signed remainder");
      run_op(64'h1234_5678_FFFF_FF9C, 64'h5555_5555_0000_0007, 0, 0, 1, "R6 half unsigned");
      run_op(64'h0000_0001_FFFF_FFFF, 64'd1, 0, 0, 1, "R6 half unsigned bit31 set");
      run_op(64'h0000_0000_8000_0000, 64'hFFFF_FFFF, 1, 0, 1, "R6 half most negative by -1");

      // R8: second go while busy must be ignored
      cur_tag = "R8 go while busy ignored";
      @(negedge clk);
      op_a = 64'hFFFF_0000_1234_5678; op_b = 64'd13; op_signed = 0; op_rem = 0; op_half = 0; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (5) @(negedge clk);
      op_a = 64'd9; op_b = 64'd2; op_rem = 1; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      begin
         int cyc = 0;
         while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
         end
         chk(done == 1'b1, "R8 first operation completes", 64'(done), 64'd1);
      end
      @(negedge clk);

      // R9: reset in the middle of an operation
      cur_tag = "R9 op aborted";
      op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'd5; op_signed = 0; op_rem = 0; op_half = 0; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (6) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      begin
         bit seen = 0;
         for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) seen = 1;
         end
         chk(seen == 0, "R9 no done after mid-op reset", 64'(seen), 64'd0);
      end
      run_op(64'd1000, 64'd33, 0, 1, 0, "R9 works after reset");

      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule